// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block holds the interrupt status of a two-channel disk controller. It sits behind a 32-bit configuration port with byte enables. Each channel's pending flag can be read and cleared at two places: a legacy status byte and a shared mode byte. Software sees the same value at both places, and a clear through either place removes the flag from both.

Each channel drives a level-sensitive interrupt line. A change of that level is a channel event. A rising level sets the channel's flag and a falling level clears it. A per-channel block bit keeps a pending flag from reaching the single interrupt output. The block bits are loaded through a separate strobe from the DMA-side register window, because the configuration port cannot write them. A read-only control byte reports which channels are enabled. All other bytes in the configuration window read as zero.

Top module: `dual_irq_mirror`

## Requirements
- R1: After reset both flags and both block bits are 0 and `irq_o` is low. Byte 0x51 reads 0x04, or 0x0C when `SECONDARY` is 1. That byte is read-only.
- R2: A rising level on `chan_irq[c]` sets flag c in the next cycle. Flag 0 reads at byte 0x50 bit 2 and at byte 0x71 bit 2. Flag 1 reads at byte 0x57 bit 4 and at byte 0x71 bit 3.
- R3: A falling level on `chan_irq[c]` clears flag c in the next cycle, at both places it reads.
- R4: A level held steady does not change a flag. A flag cleared by software while its line stays high remains clear.
- R5: Writing 1 to byte 0x50 bit 2, with its byte enable set, clears flag 0. Writing 1 to byte 0x57 bit 4 clears flag 1. The cleared flag reads 0 at both places on the next cycle.
- R6: Writing 1 to byte 0x71 bit 2 or bit 3 clears flag 0 or flag 1 respectively, at both places.
- R7: These writes change no state: zero bits, other bits of bytes 0x50, 0x57 and 0x71 (the block bits included), byte 0x51, and any byte whose enable is low.
- R8: When a rising level and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` = (flag0 AND NOT block0) OR (flag1 AND NOT block1). It follows the registered state, so it changes one cycle after an event or write.
- R10: When `blk_we` is high, block bits 1:0 load `blk_wdata` at the next edge. They read at byte 0x71 bits 4 (channel 0) and 5 (channel 1).
- R11: Every byte in the window other than 0x50, 0x51, 0x57 and 0x71 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Dword address; byte address = {cfg_addr, lane} |
| cfg_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| blk_we | input | 1 | Block-bit load strobe |
| blk_wdata | input | 2 | New block bits, bit c for channel c |
| chan_irq | input | 2 | Channel interrupt levels |
| irq_o | output | 1 | Combined interrupt level |

## Verification
The hardest case to reach is a write-one-to-clear that lands in the same cycle as a rising level on the same channel. The bench first drops the line, then raises it together with the clearing write in one drive slot, once through the legacy byte and once through the mode byte. A second hard case is a line held high through a software clear. Every clearing write in the sweep is issued with both lines held high, so a design that re-arms from the level and not from an edge shows up at once. The clearing sweeps cover all 256 byte values on each of the three status bytes, with the target byte enable both set and cleared.

// File: rtl/dual_irq_mirror_pkg.sv
package dual_irq_mirror_pkg;
  localparam int NCH       = 2;
  localparam int DW        = 32;
  localparam int LANES     = DW / 8;
  localparam int LANE_W    = $clog2(LANES);
  // byte addresses within the configuration window
  localparam logic [7:0] STAT0_BYTE = 8'h50;
  localparam logic [7:0] CTRL_BYTE  = 8'h51;
  localparam logic [7:0] STAT1_BYTE = 8'h57;
  localparam logic [7:0] MODE_BYTE  = 8'h71;
  // bit positions
  localparam int STAT0_BIT    = 2;
  localparam int STAT1_BIT    = 4;
  localparam int MODE_FLG_LSB = 2;
  localparam int MODE_BLK_LSB = 4;
  localparam int CTRL_EN_LSB  = 2;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic flag_o
);
  logic lvl_q;
  logic rise, fall;

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (rise)               flag_o <= 1'b1;
      else if (fall || clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import dual_irq_mirror_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit SECONDARY = 1'b0
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH-1:0]    flag,
  input  logic [NCH-1:0]    blk,
  output logic [NCH-1:0]    clr,
  output logic [DW-1:0]     rdata
);
  localparam int BA_W = ADDR_W + LANE_W;
  localparam logic [7:0] CTRL_VAL =
    8'(1 << CTRL_EN_LSB) | (SECONDARY ? 8'(1 << (CTRL_EN_LSB + 1)) : 8'h00);

  logic [LANES-1:0][NCH-1:0] lane_clr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BA_W-1:0] ba;
    logic [7:0]      wb, rb;
    logic [NCH-1:0]  c;
    logic            hit;

    assign ba  = {addr, LANE_W'(l)};
    assign wb  = wdata[8*l +: 8];
    assign hit = wr & be[l];

    always_comb begin
      rb = 8'h00;
      c  = '0;
      if (ba == BA_W'(STAT0_BYTE)) begin
        rb[STAT0_BIT] = flag[0];
        c[0]          = hit & wb[STAT0_BIT];
      end else if (ba == BA_W'(CTRL_BYTE)) begin
        rb = CTRL_VAL;
      end else if (ba == BA_W'(STAT1_BYTE)) begin
        rb[STAT1_BIT] = flag[1];
        c[1]          = hit & wb[STAT1_BIT];
      end else if (ba == BA_W'(MODE_BYTE)) begin
        rb[MODE_FLG_LSB +: NCH] = flag;
        rb[MODE_BLK_LSB +: NCH] = blk;
        c = {NCH{hit}} & wb[MODE_FLG_LSB +: NCH];
      end
    end

    assign rdata[8*l +: 8] = rb;
    assign lane_clr[l]     = c;
  end

  always_comb begin
    clr = '0;
    for (int l = 0; l < LANES; l++) clr = clr | lane_clr[l];
  end
endmodule

// File: rtl/dual_irq_mirror.sv
module dual_irq_mirror
  import dual_irq_mirror_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              blk_we,
  input  logic [1:0]        blk_wdata,
  input  logic [1:0]        chan_irq,
  output logic              irq_o
);
  logic [NCH-1:0] flag, clr, blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_we) blk_q <= blk_wdata;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irq_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (chan_irq[c]),
      .clr_i  (clr[c]),
      .flag_o (flag[c])
    );
  end

  cfg_window #(.ADDR_W(ADDR_W), .SECONDARY(SECONDARY)) u_win (
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .flag  (flag),
    .blk   (blk_q),
    .clr   (clr),
    .rdata (cfg_rdata)
  );

  assign irq_o = |(flag & ~blk_q);
endmodule

// File: rtl/dual_irq_mirror_checker.sv
module dual_irq_mirror_checker
  import dual_irq_mirror_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic              blk_we,
  input logic [1:0]        blk_wdata,
  input logic [1:0]        chan_irq,
  input logic [1:0]        flag,
  input logic [1:0]        blk,
  input logic              irq_o
);
  logic [1:0] prev, rise, fall;
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= chan_irq;
  end
  assign rise = chan_irq & ~prev;
  assign fall = ~chan_irq & prev;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rise[c] |=> flag[c]); // R2
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fall[c] |=> !flag[c]); // R3
    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[c]) |-> $past(rise[c])); // R4
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise[c] && !fall[c] && !cfg_wr) |=> $stable(flag[c])); // R4
  end

  AST_STAT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_W'(STAT0_BYTE >> 2) && cfg_be[0] &&
     cfg_wdata[STAT0_BIT] && !rise[0]) |=> !flag[0]); // R5
  AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_we |=> (blk == $past(blk_wdata))); // R10
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_we |=> $stable(blk)); // R7
  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&blk) |-> !irq_o); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flag)); // R9
endmodule

bind dual_irq_mirror dual_irq_mirror_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .blk_we    (blk_we),
  .blk_wdata (blk_wdata),
  .chan_irq  (chan_irq),
  .flag      (flag),
  .blk       (blk_q),
  .irq_o     (irq_o)
);

// File: tb/tb_dual_irq_mirror.sv
`timescale 1ns/1ps
module tb_dual_irq_mirror;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        blk_we;
  logic [1:0]  blk_wdata;
  logic [1:0]  chan_irq;
  logic        irq_o;

  always #2.5 clk = ~clk;

  dual_irq_mirror #(.ADDR_W(6), .SECONDARY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .blk_we(blk_we), .blk_wdata(blk_wdata), .chan_irq(chan_irq), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [1:0] m_flag, m_blk, m_prev;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] ba);
    logic [7:0] v = 8'h00;
    case (ba)
      8'h50: v[2] = m_flag[0];
      8'h51: v = 8'h0C;
      8'h57: v[4] = m_flag[1];
      8'h71: begin v[3:2] = m_flag; v[5:4] = m_blk; end
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic cyc(input logic wr, input logic [5:0] a, input logic [3:0] be,
                     input logic [31:0] d, input logic bwe, input logic [1:0] bd,
                     input logic [1:0] lvl);
    logic [1:0] rise, fall, clr;
    cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    blk_we = bwe; blk_wdata = bd; chan_irq = lvl;
    @(posedge clk);
    rise = lvl & ~m_prev; fall = ~lvl & m_prev; clr = '0;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] ba, b;
      ba = {a, 2'(l)}; b = d[8*l +: 8];
      if (wr && be[l]) begin
        if (ba == 8'h50) clr[0] = clr[0] | b[2];
        if (ba == 8'h57) clr[1] = clr[1] | b[4];
        if (ba == 8'h71) clr = clr | b[3:2];
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rise[c])                  m_flag[c] = 1'b1;
      else if (fall[c] || clr[c])   m_flag[c] = 1'b0;
    end
    if (bwe) m_blk = bd;
    m_prev = lvl;
    @(negedge clk);
    cfg_wr = 1'b0; blk_we = 1'b0;
  endtask

  task automatic idle(input logic [1:0] lvl);
    cyc(1'b0, 6'd0, 4'h0, 32'h0, 1'b0, 2'b00, lvl);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    logic [31:0] e;
    cfg_addr = a;
    #1;
    for (int l = 0; l < 4; l++) e[8*l +: 8] = exp_byte({a, 2'(l)});
    check(req, cfg_rdata, e);
  endtask

  task automatic set_flags(input logic [1:0] f);
    idle(2'b00);
    idle(f);
  endtask

  task automatic state_chk(input string req);
    rd_chk(req, 6'h14);
    rd_chk(req, 6'h15);
    rd_chk(req, 6'h1C);
    check({req, " irq"}, {31'd0, irq_o},
          {31'd0, |(m_flag & ~m_blk)});
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    blk_we = 1'b0; blk_wdata = '0; chan_irq = '0;
    m_flag = '0; m_blk = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    state_chk("R1");

    // R11 full window sweep, with every stored bit at 1
    cyc(1'b0, 6'd0, 4'h0, 32'h0, 1'b1, 2'b11, 2'b00);
    set_flags(2'b11);
    for (int a = 0; a < 64; a++) rd_chk("R11", 6'(a));

    // R9 / R10 / R2: all flag and block combinations
    for (int b = 0; b < 4; b++) begin
      for (int f = 0; f < 4; f++) begin
        cyc(1'b0, 6'd0, 4'h0, 32'h0, 1'b1, 2'(b), chan_irq);
        set_flags(2'(f));
        state_chk("R9_R10_R2");
      end
    end
    cyc(1'b0, 6'd0, 4'h0, 32'h0, 1'b1, 2'b00, chan_irq);

    // R3 falling level clears
    set_flags(2'b11);
    idle(2'b00);
    state_chk("R3");

    // R5 / R6 / R7: every byte value, target byte enabled or not, lines held high
    for (int t = 0; t < 3; t++) begin
      for (int d = 0; d < 256; d++) begin
        for (int en = 0; en < 2; en++) begin
          logic [5:0] a;
          logic [3:0] lane;
          a    = (t == 0) ? 6'h14 : (t == 1) ? 6'h15 : 6'h1C;
          lane = (t == 0) ? 4'b0001 : (t == 1) ? 4'b1000 : 4'b0010;
          set_flags(2'b11);
          cyc(1'b1, a, en ? lane : ~lane, {4{8'(d)}}, 1'b0, 2'b00, 2'b11);
          state_chk(t == 2 ? "R6_R7" : "R5_R7");
        end
      end
    end

    // R4 line held high after a clear stays cleared
    set_flags(2'b11);
    cyc(1'b1, 6'h1C, 4'b0010, 32'h0000_0C00, 1'b0, 2'b00, 2'b11);
    repeat (4) idle(2'b11);
    state_chk("R4");

    // R8 rising edge coincident with a clear
    idle(2'b00);
    idle(2'b00);
    cyc(1'b1, 6'h14, 4'b0001, 32'h0000_0004, 1'b0, 2'b00, 2'b01);
    state_chk("R8");
    check("R8 ch0", {31'd0, m_flag[0]}, 32'd1);
    cyc(1'b1, 6'h1C, 4'b0010, 32'h0000_0800, 1'b0, 2'b00, 2'b11);
    state_chk("R8");
    check("R8 ch1", {30'd0, m_flag}, 32'd3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule